// File: doc/BRIEF.md
# Serial Bit-Rate Strobe Generator

This block derives the bit timing of an asynchronous serial port from the processor clock. A single prescaler divides the processor clock by 1, 3, 4 or 13. Its output drives two independent power-of-two dividers, one for the receive side and one for the transmit side. The receive side emits a strobe at sixteen times its bit rate, which the receiver uses for oversampling. The transmit side passes through a further fixed divide-by-16 and emits one strobe per transmitted bit. Because of that extra stage, loading the same code into both selects gives the same bit rate on both sides.

Every output is a single-cycle enable in the processor clock domain, not a derived clock. Software configures the block through one 8-bit control byte. The byte can only be changed while both the transmitter and the receiver are switched off. An accepted write restarts every counter from zero. Each strobe is forced low while its own enable input is low.

Top module: `baud_gen`

## Requirements
- R1: After reset the control byte reads 0x00 and both strobe outputs are low.
- R2: The control byte has three fields: bits 7:6 hold the prescaler code (bit 7 is its high bit), bits 5:3 hold the transmit code and bits 2:0 hold the receive code. A write made while both enables are low is stored and reads back unchanged on the next cycle.
- R3: A write made while tx_en_i or rx_en_i is high leaves the control byte unchanged.
- R4: Prescaler codes 0, 1, 2 and 3 divide the processor clock by 1, 3, 4 and 13.
- R5: With prescaler divisor P and receive code n (0 to 7), rx_tick16_o pulses once every P·2^n clock cycles.
- R6: With prescaler divisor P and transmit code n, tx_bit_tick_o pulses once every 16·P·2^n clock cycles.
- R7: When the transmit code equals the receive code, the transmit period is exactly sixteen receive periods, and every transmit strobe coincides with a receive strobe.
- R8: tx_bit_tick_o is never high on two consecutive cycles. rx_tick16_o is high on consecutive cycles only when its total divisor is 1.
- R9: An accepted write clears all counters and both strobes. The first receive strobe is then high exactly P·2^n cycles after the write edge, and the first transmit strobe exactly 16·P·2^n cycles after it.
- R10: rx_tick16_o stays low while rx_en_i is low, and tx_bit_tick_o stays low while tx_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Write strobe for the control byte |
| ctl_wdata_i | input | 8 | Control byte write data |
| ctl_rdata_o | output | 8 | Current control byte |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| rx_tick16_o | output | 1 | Receive oversampling strobe (16 per bit) |
| tx_bit_tick_o | output | 1 | Transmit bit strobe |

## Verification
A prescaler counter holding a wrong limit or value stretches or shortens every strobe on both sides. The fault shows within the first strobe after the write, at most 13·128 cycles on the receive side. A fault in a rate divider appears only on its own side and only for the codes that reach the faulty counter bits, so every code is swept and both the first-strobe latency and the steady period are measured. A fault in the transmit divide-by-16 stage leaves the receive side intact but breaks the one-to-sixteen ratio. That ratio is checked directly with equal codes.

// File: rtl/baud_gen_pkg.sv
`timescale 1ns/1ps
package baud_gen_pkg;
    localparam int unsigned CTL_W     = 8;
    localparam int unsigned PRE_W     = 2;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned PRE_CNT_W = 4;
    localparam int unsigned NUM_PATHS = 2;
    localparam int unsigned RX_PATH   = 0;
    localparam int unsigned TX_PATH   = 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SEL_W-1:0] tx_sel;
        logic [SEL_W-1:0] rx_sel;
    } baud_ctl_t;

    // last count value of the prescaler (divisor minus one)
    function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [PRE_W-1:0] code);
        logic [PRE_CNT_W-1:0] r;
        case (code)
            2'd0:    r = PRE_CNT_W'(0);
            2'd1:    r = PRE_CNT_W'(2);
            2'd2:    r = PRE_CNT_W'(3);
            default: r = PRE_CNT_W'(12);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/baud_ctl_reg.sv
`timescale 1ns/1ps
module baud_ctl_reg
    import baud_gen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             busy_i,
    output baud_ctl_t        ctl_o,
    output logic             restart_o
);
    typedef struct packed {
        baud_ctl_t ctl;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic       accept;

    always_comb begin
        accept = wr_i && !busy_i;
        s_d    = s_q;
        if (accept) begin
            s_d.ctl = baud_ctl_t'(wdata_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ctl_o     = s_q.ctl;
    assign restart_o = accept;

    // R3
    locked_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && busy_i) |=> $stable(ctl_o));

    // R2
    open_write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !busy_i) |=> (ctl_o == $past(wdata_i)));
endmodule

// File: rtl/baud_prescaler.sv
`timescale 1ns/1ps
module baud_prescaler
    import baud_gen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] code_i,
    output logic             stb_o
);
    typedef struct packed {
        logic [PRE_CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t           s_d, s_q;
    logic [PRE_CNT_W-1:0] last;

    always_comb begin
        last  = pre_last(code_i);
        stb_o = (s_q.cnt == last);
        s_d   = s_q;
        if (clr_i)      s_d.cnt = '0;
        else if (stb_o) s_d.cnt = '0;
        else            s_d.cnt = s_q.cnt + PRE_CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R4
    pre_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= pre_last(code_i));
endmodule

// File: rtl/baud_pow2_div.sv
`timescale 1ns/1ps
module baud_pow2_div #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             stb_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             stb_o
);
    localparam int unsigned CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t       s_d, s_q;
    logic [CNT_W-1:0] mask;
    logic             hit;

    always_comb begin
        mask  = ~({CNT_W{1'b1}} << sel_i);
        hit   = (s_q.cnt == mask);
        stb_o = stb_i && hit;
        s_d   = s_q;
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (stb_i) begin
            s_d.cnt = hit ? '0 : s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R5
    div_cnt_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt & ~mask) == '0);
endmodule

// File: rtl/baud_gen.sv
`timescale 1ns/1ps
module baud_gen
    import baud_gen_pkg::*;
#(
    parameter int unsigned OVS_LOG = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctl_wr_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    output logic [CTL_W-1:0] ctl_rdata_o,
    input  logic             tx_en_i,
    input  logic             rx_en_i,
    output logic             rx_tick16_o,
    output logic             tx_bit_tick_o
);
    localparam int unsigned OVS_SEL_W = $clog2(OVS_LOG + 1);

    typedef struct packed {
        logic rx_tick;
        logic tx_tick;
    } out_state_t;

    out_state_t       s_d, s_q;
    baud_ctl_t        ctl;
    logic             restart;
    logic             busy;
    logic             pre_stb;
    logic             ovs_stb;
    logic [SEL_W-1:0] path_sel [NUM_PATHS];
    logic             path_stb [NUM_PATHS];

    assign busy = tx_en_i || rx_en_i;

    baud_ctl_reg u_ctl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (ctl_wr_i),
        .wdata_i   (ctl_wdata_i),
        .busy_i    (busy),
        .ctl_o     (ctl),
        .restart_o (restart)
    );

    baud_prescaler u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (restart),
        .code_i (ctl.pre),
        .stb_o  (pre_stb)
    );

    assign path_sel[RX_PATH] = ctl.rx_sel;
    assign path_sel[TX_PATH] = ctl.tx_sel;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        baud_pow2_div #(.SEL_W(SEL_W)) u_rate (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (restart),
            .stb_i  (pre_stb),
            .sel_i  (path_sel[p]),
            .stb_o  (path_stb[p])
        );
    end

    baud_pow2_div #(.SEL_W(OVS_SEL_W)) u_tx_ovs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (restart),
        .stb_i  (path_stb[TX_PATH]),
        .sel_i  (OVS_SEL_W'(OVS_LOG)),
        .stb_o  (ovs_stb)
    );

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d = '0;
        end else begin
            s_d.rx_tick = path_stb[RX_PATH] && rx_en_i;
            s_d.tx_tick = ovs_stb && tx_en_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ctl_rdata_o   = ctl;
    assign rx_tick16_o   = s_q.rx_tick;
    assign tx_bit_tick_o = s_q.tx_tick;

    // R10
    rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_tick16_o |-> $past(rx_en_i));

    // R10
    tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_bit_tick_o |-> $past(tx_en_i));

    // R8
    tx_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_bit_tick_o |=> !tx_bit_tick_o);

    // R7
    tx_on_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_bit_tick_o && $past(rx_en_i) && (ctl.tx_sel == ctl.rx_sel)) |-> rx_tick16_o);

    // R9
    restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_wr_i && !busy) |=> (!rx_tick16_o && !tx_bit_tick_o));
endmodule

// File: tb/baud_gen_tb_top.sv
`timescale 1ns/1ps
module baud_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       rx_tick16;
    logic       tx_bit_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    baud_gen dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ctl_wr_i      (ctl_wr),
        .ctl_wdata_i   (ctl_wdata),
        .ctl_rdata_o   (ctl_rdata),
        .tx_en_i       (tx_en),
        .rx_en_i       (rx_en),
        .rx_tick16_o   (rx_tick16),
        .tx_bit_tick_o (tx_bit_tick)
    );

    function automatic int pre_div(input int code);
        case (code)
            0: return 1;
            1: return 3;
            2: return 4;
            default: return 13;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // write with both enables low; returns at the negedge after the write edge
    task automatic program_ctl(input logic [7:0] v);
        @(negedge clk);
        rx_en = 1'b0;
        tx_en = 1'b0;
        ctl_wr = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_pulse(input bit use_tx, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(use_tx ? tx_bit_tick : rx_tick16) && n < limit);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        int cnt;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", int'(ctl_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", int'(ctl_rdata), 0);
        chk("R1 rx strobe low", int'(rx_tick16), 0);
        chk("R1 tx strobe low", int'(tx_bit_tick), 0);

        // R2 field readback
        program_ctl(8'hC9);
        chk("R2 readback C9", int'(ctl_rdata), 8'hC9);
        program_ctl(8'h36);
        chk("R2 readback 36", int'(ctl_rdata), 8'h36);

        // R3 locked writes
        program_ctl(8'h5A);
        tx_en = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = 8'hFF;
        @(negedge clk);
        ctl_wr = 1'b0;
        @(negedge clk);
        chk("R3 write ignored with tx_en", int'(ctl_rdata), 8'h5A);
        tx_en = 1'b0; rx_en = 1'b1;
        ctl_wr = 1'b1; ctl_wdata = 8'h00;
        @(negedge clk);
        ctl_wr = 1'b0;
        @(negedge clk);
        chk("R3 write ignored with rx_en", int'(ctl_rdata), 8'h5A);

        // R4 R5 R9 receive sweep over every prescaler and receive code
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                program_ctl(8'((p << 6) | (c << 3) | c));
                rx_en = 1'b1;
                wait_pulse(1'b0, 4000, n);
                chk($sformatf("R9 R4 rx first p%0d c%0d", p, c), n, pre_div(p) << c);
                wait_pulse(1'b0, 4000, n);
                chk($sformatf("R5 rx period p%0d c%0d", p, c), n, pre_div(p) << c);
            end
        end

        // R6 R8 R9 transmit sweep
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 8; c++) begin
                int pp;
                int cc;
                pp = (p == 2) ? 3 : p;
                cc = (p == 2) ? 2 : c;
                if (p == 2 && c > 0) break;
                program_ctl(8'((pp << 6) | (cc << 3) | cc));
                tx_en = 1'b1;
                wait_pulse(1'b1, 40000, n);
                chk($sformatf("R9 tx first p%0d c%0d", pp, cc), n, 16 * (pre_div(pp) << cc));
                @(negedge clk);
                chk("R8 tx one cycle", int'(tx_bit_tick), 0);
                wait_pulse(1'b1, 40000, n);
                chk($sformatf("R6 tx period p%0d c%0d", pp, cc), n + 1, 16 * (pre_div(pp) << cc));
            end
        end

        // R7 equal codes: sixteen rx strobes per tx strobe, last one coincident
        program_ctl({2'd1, 3'd2, 3'd2});
        rx_en = 1'b1; tx_en = 1'b1;
        cnt = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (rx_tick16) cnt++;
        end while (!tx_bit_tick && n < 2000);
        chk("R7 rx strobes per tx strobe", cnt, 16);
        chk("R7 rx coincides with tx", int'(rx_tick16), 1);

        // R5 R6 independent codes
        program_ctl({2'd2, 3'd0, 3'd5});
        rx_en = 1'b1; tx_en = 1'b1;
        wait_pulse(1'b1, 4000, n);
        chk("R6 tx first pre4 code0", n, 64);
        chk("R5 rx not yet at 64", int'(rx_tick16), 0);
        wait_pulse(1'b0, 4000, n);
        chk("R5 rx first pre4 code5", n + 64, 128);

        // R10 gating: divisor 1, enables low
        program_ctl(8'h00);
        cnt = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rx_tick16 || tx_bit_tick) cnt++;
        end
        chk("R10 strobes low while disabled", cnt, 0);
        rx_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 rx high every cycle at divisor 1", int'(rx_tick16), 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R10 rx low after disable", int'(rx_tick16), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule